// File: doc/BRIEF.md
# Time-Slot Shared Memory Hub

This block lets eight identical requesters share one single-port memory of 32-bit words. Access is not arbitrated on demand. A free-running commutator hands the memory to each port in turn, in a fixed ascending order, and each port owns its slot for two clocks. A port that has nothing to do when its slot comes round leaves the memory idle for that slot. No other port can take it over. Every port therefore gets the same share of the memory whatever the others do, and its latency depends only on where the rotation stands when it asks.

A requester raises its request together with the write enable, word address and write data, and holds them until its done strobe pulses. The access is taken in the first clock of the port's slot. Done follows a fixed number of clocks later, together with the read data. With the default parameters, a full rotation takes 16 clocks and an operation completes 7 to 22 clocks after it is requested. `AW` = 13 gives the full 32 KB region of 8192 words. The default is kept smaller for elaboration.

Top module: `slot_hub`

## Requirements
- R1: While reset is held, and in the first clock after it is released, every done bit is low and every read-data slice is zero.
- R2: Slots rotate over NPORT*SLOT_CLKS = 16 clocks, counted from the first clock after reset release as clock 0. Port p (0 to 7, ascending) owns clocks 2p and 2p+1 of each rotation. A request is taken only if it is present in clock 2p, the first clock of the slot.
- R3: A request present in the first clock of its port's slot completes with done exactly 7 clocks later. Any request completes between 7 and 22 clocks after it is first presented.
- R4: A request first presented in the second clock of its own slot is not taken in that slot. It waits for the next rotation and completes 22 clocks after it was presented.
- R5: An unused slot is not given to another port. Port 1 requesting at clock 0 of a rotation, with port 0 idle, completes 9 clocks later.
- R6: Done (bit p of `done_o`) is a one-clock pulse on the issuing port only. For a read, the stored word appears on that port's read-data slice (bits p*32 up to p*32+31) in the same clock as done.
- R7: A write stores its data at the addressed word. The done of the write presents the content that word held before the write.
- R8: Accesses from different ports to one word take effect in slot order. A read whose slot follows a write's slot in the same rotation returns the new value. A read whose slot precedes it returns the old value.
- R9: A port's read-data slice changes only in a clock where that port's done is high. Operations by other ports leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NPORT | Per-port request, held until done |
| we_i | input | NPORT | Per-port write enable |
| addr_i | input | NPORT*AW | Per-port word address, port p in slice p |
| wdata_i | input | NPORT*DW | Per-port write data |
| rdata_o | output | NPORT*DW | Per-port read data, registered |
| done_o | output | NPORT | Per-port one-clock completion strobe |

## Verification
The bench builds the hub with its defaults: eight ports, two clocks per slot, a completion delay of 7 and 2048 words. This gives a 16-clock rotation, so both latency extremes, 7 and 22, can be reached by placing a request at a chosen clock of the rotation. Random traffic is confined to 16 words, which makes writes and reads from different ports collide often within one rotation and exercises slot ordering and read-before-write return values. Directed cases pin a request to the first clock of its slot, the second clock of its slot, and an idle neighbour's slot.

// File: rtl/hub_pkg.sv
package hub_pkg;
  // Slot owner for a position in the rotation.
  function automatic int hub_slot_of(int pos, int slot_clks);
    return pos / slot_clks;
  endfunction

  // True in the first clock of any slot.
  function automatic bit hub_slot_head(int pos, int slot_clks);
    return (pos % slot_clks) == 0;
  endfunction
endpackage

// File: rtl/slot_timer.sv
module slot_timer import hub_pkg::*; #(
  parameter int NPORT     = 8,
  parameter int SLOT_CLKS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  output logic [$clog2(NPORT)-1:0]          slot_idx,
  output logic                              slot_open
);
  localparam int ROT = NPORT * SLOT_CLKS;
  localparam int CW  = $clog2(ROT);
  localparam int PW  = $clog2(NPORT);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     pos_q <= '0;
    else if (pos_q == CW'(ROT - 1)) pos_q <= '0;
    else                            pos_q <= pos_q + 1'b1;
  end

  always_comb begin
    slot_idx  = PW'(hub_slot_of(int'(pos_q), SLOT_CLKS));
    slot_open = hub_slot_head(int'(pos_q), SLOT_CLKS);
  end

  AST_SLOT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    slot_open |=> !slot_open); // R4
endmodule

// File: rtl/hub_store.sv
module hub_store #(
  parameter int DW = 32,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          acc_v,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // Read-first: the returned word is the content before any write.
  always_ff @(posedge clk) begin
    if (acc_v) begin
      acc_rdata <= mem_q[acc_addr];
      if (acc_we) mem_q[acc_addr] <= acc_wdata;
    end
  end
endmodule

// File: rtl/hub_pipe.sv
module hub_pipe #(
  parameter int NPORT = 8,
  parameter int DW    = 32,
  parameter int LAT   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_v,
  input  logic [$clog2(NPORT)-1:0] iss_port,
  input  logic [DW-1:0]            mem_rd,
  output logic [NPORT-1:0]         done_o,
  output logic [NPORT*DW-1:0]      rdata_o
);
  localparam int PW  = $clog2(NPORT);
  localparam int NST = LAT - 1;

  logic [NST:1]  v_q;
  logic [PW-1:0] p_q  [1:NST];
  logic [DW-1:0] d_q  [2:NST];
  logic [DW-1:0] d_in [2:NST];
  logic [DW-1:0] rd_q [NPORT];

  always_comb begin
    d_in[2] = mem_rd;
    for (int k = 3; k <= NST; k++) d_in[k] = d_q[k-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 1; k <= NST; k++) p_q[k] <= '0;
    end else begin
      v_q[1] <= iss_v;
      p_q[1] <= iss_port;
      for (int k = 2; k <= NST; k++) begin
        v_q[k] <= v_q[k-1];
        p_q[k] <= p_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 2; k <= NST; k++) d_q[k] <= d_in[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= '0;
      for (int p = 0; p < NPORT; p++) rd_q[p] <= '0;
    end else begin
      done_o <= v_q[NST] ? (NPORT'(1) << p_q[NST]) : '0;
      if (v_q[NST]) rd_q[p_q[NST]] <= d_q[NST];
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_out
    assign rdata_o[g*DW +: DW] = rd_q[g];
  end
endmodule

// File: rtl/slot_hub.sv
module slot_hub #(
  parameter int NPORT     = 8,
  parameter int DW        = 32,
  parameter int AW        = 11,
  parameter int SLOT_CLKS = 2,
  parameter int LAT       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_i,
  input  logic [NPORT-1:0]    we_i,
  input  logic [NPORT*AW-1:0] addr_i,
  input  logic [NPORT*DW-1:0] wdata_i,
  output logic [NPORT*DW-1:0] rdata_o,
  output logic [NPORT-1:0]    done_o
);
  localparam int PW = $clog2(NPORT);

  logic [PW-1:0]    slot_idx;
  logic             slot_open;
  logic             issue_v;
  logic             issue_we;
  logic [AW-1:0]    issue_addr;
  logic [DW-1:0]    issue_wdata;
  logic [DW-1:0]    mem_rd;
  logic [NPORT-1:0] grant_vec;
  logic [NPORT-1:0] outst_q;

  slot_timer #(.NPORT(NPORT), .SLOT_CLKS(SLOT_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .slot_open(slot_open)
  );

  // Only the slot owner is looked at; nobody else can use the slot.
  always_comb begin
    issue_v     = slot_open & req_i[slot_idx];
    issue_we    = we_i[slot_idx];
    issue_addr  = addr_i[int'(slot_idx)*AW +: AW];
    issue_wdata = wdata_i[int'(slot_idx)*DW +: DW];
    grant_vec   = issue_v ? (NPORT'(1) << slot_idx) : '0;
  end

  hub_store #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .acc_v(issue_v), .acc_we(issue_we), .acc_addr(issue_addr),
    .acc_wdata(issue_wdata), .acc_rdata(mem_rd)
  );

  hub_pipe #(.NPORT(NPORT), .DW(DW), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .iss_v(issue_v), .iss_port(slot_idx),
    .mem_rd(mem_rd), .done_o(done_o), .rdata_o(rdata_o)
  );

  // Per-port in-flight flag, used by the checks below.
  always_ff @(posedge clk) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= (outst_q | grant_vec) & ~done_o;
  end

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & outst_q) == '0); // R3
  AST_DONE_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o & ~outst_q) == '0); // R6
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o)); // R6

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_o[g*DW +: DW]) |-> done_o[g]); // R9
  end
endmodule

// File: tb/slot_hub_tb_top.sv
module slot_hub_tb_top;
  localparam int CLK_NS = 10;
  localparam int NP = 8, DW = 32, AW = 11, ROT = 16, LATC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [NP-1:0]    req = '0, we = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*DW-1:0] wdata = '0;
  logic [NP*DW-1:0] rdata;
  logic [NP-1:0]    done;

  slot_hub dut_i (.clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
                  .wdata_i(wdata), .rdata_o(rdata), .done_o(done));

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [0:15];
  bit            known [0:15];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Position 2p of the rotation is the first clock of port p's slot.
  function automatic int first_take(int s, int p);
    int k = s;
    while ((k % ROT) != 2 * p) k++;
    return k;
  endfunction

  task automatic wait_pos(int m);
    while ((cyc % ROT) != m) @(negedge clk);
  endtask

  task automatic op(int p, bit w, int a, logic [DW-1:0] d, string tag,
                    output int lat, output logic [DW-1:0] rv);
    int s = cyc;
    int g = first_take(s, p);
    bit seen = 0;
    bit kn = 0;
    logic [DW-1:0] ev = '0;
    req[p] = 1'b1; we[p] = w;
    addr[p*AW +: AW] = AW'(a); wdata[p*DW +: DW] = d;
    lat = -1; rv = '0;
    if (g == s) begin
      ev = model[a]; kn = known[a];
      if (w) begin model[a] = d; known[a] = 1; end
    end
    while (!seen && cyc <= g + LATC + 2) begin
      @(negedge clk);
      if (cyc == g) begin
        ev = model[a]; kn = known[a];
        if (w) begin model[a] = d; known[a] = 1; end
      end
      if (done[p]) begin
        seen = 1; lat = cyc - s; rv = rdata[p*DW +: DW];
      end
    end
    req[p] = 1'b0; we[p] = 1'b0;
    chk(lat == g - s + LATC, tag, $sformatf("latency port %0d", p), lat, g - s + LATC);
    if (kn) chk(rv == ev, w ? "R7" : "R6", $sformatf("returned word port %0d", p), rv, ev);
    @(negedge clk);
    chk(!done[p], "R6", $sformatf("done pulse width port %0d", p), done[p], 0);
  endtask

  task automatic rnd_branch(int p);
    int lat;
    logic [DW-1:0] rv;
    if ($urandom_range(1, 0) == 1) begin
      repeat ($urandom_range(20, 0)) @(negedge clk);
      op(p, 1'($urandom_range(1, 0)), int'($urandom_range(15, 0)), $urandom, "R2", lat, rv);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [DW-1:0] rv, r1, r6, held;
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    chk(done == '0, "R1", "done in reset", done, 0);
    chk(rdata == '0, "R1", "rdata in reset", rdata[31:0], 0);
    rst_n = 1'b1;
    chk(done == '0 && rdata == '0, "R1", "outputs after release", done, 0);

    for (int a = 0; a < 16; a++)
      op(a % NP, 1'b1, a, 32'hA500_0000 ^ (a * 32'h0101_0101), "R3", lat, rv);

    wait_pos(6);
    op(3, 1'b0, 5, '0, "R3", lat, rv);
    chk(lat == 7, "R3", "latency at slot head", lat, 7);
    chk(rv == (32'hA500_0000 ^ (5 * 32'h0101_0101)), "R6", "read word 5", rv,
        32'hA500_0000 ^ (5 * 32'h0101_0101));

    wait_pos(9);
    op(4, 1'b0, 6, '0, "R4", lat, rv);
    chk(lat == 22, "R4", "latency from slot second clock", lat, 22);

    wait_pos(0);
    op(1, 1'b0, 2, '0, "R5", lat, rv);
    chk(lat == 9, "R5", "idle slot 0 not borrowed", lat, 9);

    op(2, 1'b1, 7, 32'hDEAD_BEEF, "R7", lat, rv);
    chk(rv == (32'hA500_0000 ^ (7 * 32'h0101_0101)), "R7", "write returns old", rv,
        32'hA500_0000 ^ (7 * 32'h0101_0101));
    op(0, 1'b0, 7, '0, "R7", lat, rv);
    chk(rv == 32'hDEAD_BEEF, "R7", "write stored", rv, 32'hDEAD_BEEF);

    wait_pos(0);
    fork
      op(1, 1'b0, 9, '0, "R8", lat, r1);
      begin int l3; logic [DW-1:0] v3; op(3, 1'b1, 9, 32'h1234_5678, "R8", l3, v3); end
      begin int l6; op(6, 1'b0, 9, '0, "R8", l6, r6); end
    join
    chk(r1 == (32'hA500_0000 ^ (9 * 32'h0101_0101)), "R8", "earlier slot sees old", r1,
        32'hA500_0000 ^ (9 * 32'h0101_0101));
    chk(r6 == 32'h1234_5678, "R8", "later slot sees new", r6, 32'h1234_5678);

    op(2, 1'b0, 4, '0, "R9", lat, rv);
    held = rdata[2*DW +: DW];
    op(5, 1'b1, 4, 32'h0BAD_F00D, "R9", lat, rv);
    op(2 + 1, 1'b0, 4, '0, "R9", lat, rv);
    chk(rdata[2*DW +: DW] == held, "R9", "port 2 rdata held", rdata[2*DW +: DW], held);

    for (int r = 0; r < 30; r++) begin
      fork
        rnd_branch(0); rnd_branch(1); rnd_branch(2); rnd_branch(3);
        rnd_branch(4); rnd_branch(5); rnd_branch(6); rnd_branch(7);
      join
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule